// File: doc/BRIEF.md
# Stream-to-Serial Transmit Bridge

This block takes bytes from a stream slave port with a valid/ready handshake and sends them out as parity-framed asynchronous serial characters on one transmit line. An eight-entry synchronous FIFO sits between the port and the serializer. The FIFO can take a byte and give one up in the same clock. Backpressure on the port therefore comes from FIFO occupancy and not from the serializer. A bit-rate counter, sized at elaboration from the system clock frequency and the line rate, paces each bit.

The serializer is a state machine with five states. TX_IDLE holds the line high and reports ready. TX_START drives the low start bit. TX_DATA shifts out eight data bits, least significant first. TX_PARITY sends the parity bit. TX_STOP drives the high stop bit. The transitions are as follows. TX_IDLE goes to TX_START on a load, which happens when the FIFO is not empty. TX_START goes to TX_DATA on a bit tick. TX_DATA stays in TX_DATA on a tick until the eighth bit, and then goes to TX_PARITY. TX_PARITY goes to TX_STOP on a tick. TX_STOP goes to TX_IDLE on a tick. A started frame always runs to the end.

Top module: `stream_serial_bridge`

## Requirements
- R1: A byte is taken from `in_data` only on a rising clock edge where `in_valid` and `in_ready` are both high. Taken bytes leave the line in the order they were taken. A byte offered while `in_ready` is low never appears on the line.
- R2: `in_ready` is high exactly when fewer than DEPTH (default 8) bytes are stored. From an empty, idle block, a continuously offered stream is accepted for exactly DEPTH+1 bytes: one moves into the serializer and DEPTH fill the FIFO. After that `in_ready` is low.
- R3: A write and a pop in the same cycle both take effect, and no byte is lost or duplicated.
- R4: Each character is a start bit of 0, then 8 data bits with bit 0 first, then one parity bit, then one stop bit of 1.
- R5: With ODD_PARITY=0 (the default) the parity bit equals the XOR of the 8 data bits, which gives even parity. With ODD_PARITY=1 it is the inverse.
- R6: Every bit lasts BIT_CYC = (CLK_HZ + BAUD/2) / BAUD clock cycles, where BAUD defaults to 115200.
- R7: `tx_ready` is high exactly when the serializer is in TX_IDLE. It is low for the whole frame. A byte is popped only when `tx_ready` is high and the FIFO is not empty.
- R8: During and after reset, `tx_line` is high, `in_ready` is high and `tx_ready` is high. With no input offered the line stays high.
- R9: A started frame runs to completion while the port keeps accepting bytes. With bytes queued, consecutive start bits begin 11*BIT_CYC+1 cycles apart, because one idle-high clock follows each stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is offered |
| in_ready | output | 1 | FIFO has room for a byte |
| tx_line | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Serializer can take a new byte |

## Verification
The assertions assume that reset is held for at least one clock edge before the first transfer and that DEPTH is at least 2. They also assume CLK_HZ is at least the line rate, so that a bit lasts at least one cycle. They make no assumption about `in_valid`, which may be held high against a full FIFO. The bench resets for several cycles, changes inputs only on falling edges, and uses a clock rate of eight cycles per bit so that frames are short. It deliberately holds `in_valid` high through backpressure, so that the full-FIFO path is exercised and is not avoided.

// File: rtl/uart_bridge_pkg.sv
package uart_bridge_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    // Rounded clock cycles per serial bit.
    function automatic int unsigned bit_cycles(input int unsigned clk_hz,
                                               input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);

    // R2
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> cnt != '0);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> cnt == $past(cnt));

endmodule

// File: rtl/bridge_baud.sv
module bridge_baud #(
    parameter int BIT_CYC = 434
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(BIT_CYC + 1);
    localparam logic [CW-1:0] TOP = CW'(BIT_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R6
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

endmodule

// File: rtl/bridge_tx_fsm.sv
module bridge_tx_fsm
    import uart_bridge_pkg::*;
#(
    parameter int DW         = 8,
    parameter bit ODD_PARITY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          tick,
    output logic          ready,
    output logic          tx
);
    localparam int IW = $clog2(DW);
    localparam logic [IW-1:0] LAST_BIT = IW'(DW - 1);

    tx_state_e     state, state_nx;
    logic [DW-1:0] shreg;
    logic [IW-1:0] idx;
    logic          par;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (load) state_nx = TX_START;
            TX_START:  if (tick) state_nx = TX_DATA;
            TX_DATA:   if (tick && idx == LAST_BIT) state_nx = TX_PARITY;
            TX_PARITY: if (tick) state_nx = TX_STOP;
            TX_STOP:   if (tick) state_nx = TX_IDLE;
            default:   state_nx = TX_IDLE;
        endcase
    end

    // Datapath register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            par   <= 1'b0;
        end else if (load) begin
            shreg <= load_data;
            idx   <= '0;
            par   <= (^load_data) ^ ODD_PARITY;
        end else if (state == TX_DATA && tick) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ready = 1'b0;
        tx    = 1'b1;
        unique case (state)
            TX_IDLE:   ready = 1'b1;
            TX_START:  tx = 1'b0;
            TX_DATA:   tx = shreg[0];
            TX_PARITY: tx = par;
            TX_STOP:   tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end

    // R7
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> state == TX_IDLE);

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !tick) |=> state == $past(state));

endmodule

// File: rtl/stream_serial_bridge.sv
module stream_serial_bridge
    import uart_bridge_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BAUD       = 115_200,
    parameter int          DEPTH      = 8,
    parameter bit          ODD_PARITY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       tx_line,
    output logic       tx_ready
);
    localparam int DW      = 8;
    localparam int BIT_CYC = int'(bit_cycles(CLK_HZ, BAUD));

    logic          full, empty, wr_en, pop, tick;
    logic [DW-1:0] head;

    assign in_ready = !full;
    assign wr_en    = in_valid && in_ready;
    assign pop      = tx_ready && !empty;

    bridge_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(in_data),
        .rd_en(pop), .rd_data(head),
        .full(full), .empty(empty)
    );

    bridge_baud #(.BIT_CYC(BIT_CYC)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(!tx_ready), .tick(tick)
    );

    bridge_tx_fsm #(.DW(DW), .ODD_PARITY(ODD_PARITY)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(pop), .load_data(head), .tick(tick),
        .ready(tx_ready), .tx(tx_line)
    );

    // R8
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && $past(tx_ready)) |-> tx_line);

endmodule

// File: tb/tb_stream_serial_bridge.sv
module tb_stream_serial_bridge;
    localparam int unsigned BAUD   = 115_200;
    localparam int unsigned CLK_HZ = BAUD * 8;
    localparam int BIT = (CLK_HZ + BAUD / 2) / BAUD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0;
    logic o_valid = 1'b0;
    logic in_ready, tx_line, tx_ready;
    logic o_ready, o_line, o_txr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_sel = 1'b0;
    logic mon_line;

    logic [7:0] rx_data[$];
    logic       rx_par[$];
    logic       rx_frm[$];
    int         rx_time[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign mon_line = mon_sel ? o_line : tx_line;

    stream_serial_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_line(tx_line), .tx_ready(tx_ready));

    stream_serial_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b1)) dut_odd (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(o_valid),
        .in_ready(o_ready), .tx_line(o_line), .tx_ready(o_txr));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Frame monitor: mid-bit sampling on falling edges
    initial begin
        logic [7:0] d;
        logic p, ok;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (mon_line == 1'b0) begin
                rx_time.push_back(cyc);
                repeat (BIT / 2) @(negedge clk);
                ok = (mon_line == 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    d[i] = mon_line;
                end
                repeat (BIT) @(negedge clk);
                p = mon_line;
                repeat (BIT) @(negedge clk);
                ok = ok && (mon_line == 1'b1);
                rx_data.push_back(d);
                rx_par.push_back(p);
                rx_frm.push_back(ok);
            end
        end
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int t = 0;
        while (rx_data.size() < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic clear_rx();
        rx_data.delete(); rx_par.delete(); rx_frm.delete(); rx_time.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tx_line == 1'b1, "R8 line high after reset", tx_line, 1);
        check(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);
        check(tx_ready == 1'b1, "R8 tx_ready after reset", tx_ready, 1);
        repeat (50) @(negedge clk);
        check(tx_line == 1'b1, "R8 line stays high idle", tx_line, 1);
        check(rx_data.size() == 0, "R8 no frame when idle", rx_data.size(), 0);
    endtask

    task automatic t_single();
        int low_len = 0;
        clear_rx();
        fork
            push(8'h01);
            begin
                @(negedge clk iff tx_line == 1'b0);
                while (tx_line == 1'b0) begin
                    low_len++;
                    @(negedge clk);
                end
            end
            begin
                @(negedge clk iff tx_line == 1'b0);
                repeat (5 * BIT) @(negedge clk);
                check(tx_ready == 1'b0, "R7 tx_ready low mid-frame", tx_ready, 0);
            end
        join
        wait_frames(1);
        repeat (4) @(negedge clk);
        check(low_len == BIT, "R6 bit period", low_len, BIT);
        check(rx_data.size() == 1, "R4 one frame", rx_data.size(), 1);
        if (rx_data.size() == 1) begin
            check(rx_data[0] == 8'h01, "R4 data LSB first", rx_data[0], 8'h01);
            check(rx_frm[0] == 1'b1, "R4 start and stop", rx_frm[0], 1);
            check(rx_par[0] == 1'b1, "R5 even parity 0x01", rx_par[0], 1);
        end
        check(tx_ready == 1'b1, "R7 tx_ready after frame", tx_ready, 1);
    endtask

    task automatic t_parity_even();
        clear_rx();
        push(8'hA5);
        wait_frames(1);
        push(8'h07);
        wait_frames(2);
        check(rx_data.size() == 2, "R4 two frames", rx_data.size(), 2);
        if (rx_data.size() == 2) begin
            check(rx_data[0] == 8'hA5, "R4 data 0xA5", rx_data[0], 8'hA5);
            check(rx_par[0] == 1'b0, "R5 even parity 0xA5", rx_par[0], 0);
            check(rx_data[1] == 8'h07, "R4 data 0x07", rx_data[1], 8'h07);
            check(rx_par[1] == 1'b1, "R5 even parity 0x07", rx_par[1], 1);
        end
    endtask

    task automatic t_burst();
        int n = 0;
        clear_rx();
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            in_data  = 8'(n * 37 + 5);
            in_valid = 1'b1;
            if (in_ready) n++;
        end
        @(negedge clk);
        check(in_ready == 1'b0, "R2 in_ready low when full", in_ready, 0);
        in_valid = 1'b0;
        check(n == 9, "R2 accepted DEPTH+1", n, 9);
        wait_frames(9);
        repeat (300) @(negedge clk);
        check(rx_data.size() == 9, "R1 no extra frames", rx_data.size(), 9);
        for (int i = 0; i < 9 && i < rx_data.size(); i++) begin
            check(rx_data[i] == 8'(i * 37 + 5), "R3 burst byte order", rx_data[i], 8'(i * 37 + 5));
            check(rx_frm[i] == 1'b1, "R9 frame complete", rx_frm[i], 1);
        end
        for (int i = 1; i < 9 && i < rx_time.size(); i++)
            check(rx_time[i] - rx_time[i-1] == 11 * BIT + 1, "R9 start spacing",
                  rx_time[i] - rx_time[i-1], 11 * BIT + 1);
    endtask

    task automatic t_odd();
        clear_rx();
        mon_sel = 1'b1;
        foreach (rx_data[i]) ;
        @(negedge clk);
        in_data = 8'h01;
        o_valid = 1'b1;
        @(negedge clk);
        o_valid = 1'b0;
        wait_frames(1);
        @(negedge clk);
        in_data = 8'h03;
        o_valid = 1'b1;
        @(negedge clk);
        o_valid = 1'b0;
        wait_frames(2);
        check(rx_data.size() == 2, "R5 odd frames", rx_data.size(), 2);
        if (rx_data.size() == 2) begin
            check(rx_par[0] == 1'b0, "R5 odd parity 0x01", rx_par[0], 0);
            check(rx_par[1] == 1'b1, "R5 odd parity 0x03", rx_par[1], 1);
            check(rx_data[1] == 8'h03, "R4 odd data", rx_data[1], 8'h03);
        end
        mon_sel = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_parity_even();
        t_burst();
        t_odd();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule